// File: doc/BRIEF.md
# Programmable Frame-Sync Pulse Generator

This block makes a periodic frame-synchronization pulse. It runs on the system clock and moves forward only on cycles where a one-cycle sample-rate strobe (`tick`) is high. Two programmable fields set the shape of the pulse, and both are counted in strobes. The width field sets how many strobes the pulse stays high. The period field sets how many strobes lie between the starts of two frames.

Pulses are made only while both the generator-run control and the free-running mode select are high. If either one drops, the output goes low on the next clock and both counters clear. The next pulse then starts on the first strobe after both controls are high again. The fields are captured when a frame starts, so a field that changes during a frame first shapes the frame after it.

Top module: `fsync_gen`

## Requirements
- R1: During reset and after reset is released, `fs_out` is low.
- R2: While `run` or `free_mode` is low, `fs_out` stays low and strobes have no effect.
- R3: With both controls high, the first strobe starts a frame, and `fs_out` is high in the clock cycle after that strobe.
- R4: In each frame, `fs_out` stays high for `width_cfg`+1 strobes and then goes low, when `width_cfg` is less than `period_cfg`.
- R5: A new frame starts every `period_cfg`+1 strobes, and `fs_out` goes high again at that point.
- R6: `fs_out` changes only in the cycle after a strobe, or on a change of the control inputs.
- R7: A change to `width_cfg` or `period_cfg` during a frame takes effect at the next frame start, not during the current frame.
- R8: When `width_cfg` is greater than or equal to `period_cfg`, `fs_out` stays high without a break while the generator runs. This includes `period_cfg` = 0.
- R9: If `run` or `free_mode` drops, `fs_out` is low in the next cycle, even in the middle of a pulse, and the following frame starts fresh.
- R10: The extreme field values work: a width field of 0 gives a one-strobe pulse, and a width field of 255 with a period field of 4095 gives 256 high strobes in a 4096-strobe frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate strobe, one system clock wide |
| run | input | 1 | Generator-run control |
| free_mode | input | 1 | Free-running frame-sync mode select |
| width_cfg | input | 8 | Pulse width minus one, in strobes |
| period_cfg | input | 12 | Frame period minus one, in strobes |
| fs_out | output | 1 | Frame-synchronization output |

## Verification
The hardest case to reach from the ports is a field change that arrives partway through a frame. The old values have to stay in force until the frame boundary, and then the new ones have to be picked up. To reach it, the bench writes new fields a few strobes into a frame, at several phases. It also sends strobes with irregular gaps from an LFSR, so frame boundaries land at many different cycle positions relative to control and field changes. A behavioural phase model compares `fs_out` on every clock throughout.

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int WIDTH_BITS  = 8,
  parameter int PERIOD_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   run,
  input  logic                   free_mode,
  input  logic [WIDTH_BITS-1:0]  width_cfg,
  input  logic [PERIOD_BITS-1:0] period_cfg,
  output logic                   fs_out
);

  logic                   enabled;
  logic                   active;
  logic                   frame_start;
  logic [WIDTH_BITS-1:0]  wcnt;
  logic [PERIOD_BITS-1:0] pcnt;

  assign enabled     = run & free_mode;
  assign frame_start = !active || (pcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !enabled) begin
      active <= 1'b0;
      fs_out <= 1'b0;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (tick) begin
      if (frame_start) begin
        active <= 1'b1;
        fs_out <= 1'b1;
        wcnt   <= width_cfg;
        pcnt   <= period_cfg;
      end else begin
        pcnt <= pcnt - 1'b1;
        if (wcnt == '0) fs_out <= 1'b0;
        else            wcnt   <= wcnt - 1'b1;
      end
    end
  end

endmodule

module fsync_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic run,
  input logic free_mode,
  input logic fs_out
);

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && free_mode) |=> !fs_out);

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && run && free_mode) |=> $stable(fs_out));

  a_r3_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_out) |-> $past(tick) && $past(run && free_mode));

  a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_out) |-> $past(tick) || !$past(run && free_mode));

endmodule

bind fsync_gen fsync_gen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
  .free_mode(free_mode), .fs_out(fs_out)
);

// File: tb/fsync_gen_bench.sv
`timescale 1ns/1ps
module fsync_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        run = 1'b0;
  logic        free_mode = 1'b0;
  logic [7:0]  width_cfg = 8'd1;
  logic [11:0] period_cfg = 12'd15;
  logic        fs_out;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  fsync_gen u_fsync_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .free_mode(free_mode),
    .width_cfg(width_cfg), .period_cfg(period_cfg), .fs_out(fs_out)
  );

  // behavioural phase model
  bit act = 0;
  int ph = 0;
  int lw = 0;
  int lp = 0;
  bit exp_fs = 0;

  always @(posedge clk) begin
    if (!rst_n || !(run && free_mode)) begin
      act = 0; ph = 0; exp_fs = 0;
    end else if (tick) begin
      if (!act) begin
        act = 1; ph = 0; lw = width_cfg; lp = period_cfg;
      end else begin
        ph++;
        if (ph > lp) begin
          ph = 0; lw = width_cfg; lp = period_cfg;
        end
      end
      exp_fs = (ph <= lw);
    end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: fs_out actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) chk(fs_out == exp_fs, cur_req, fs_out, exp_fs);
  end

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic lfsr_ticks(input int n);
    logic [15:0] l = 16'hACE1;
    for (int i = 0; i < n; i++) begin
      l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
      tick = l[0];
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic stop_gen;
    run = 1'b0; free_mode = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fs_out == 1'b0, "R1 in reset", fs_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fs_out == 1'b0, "R1 after reset", fs_out, 0);

    cur_req = "R2";
    run = 1'b1; free_mode = 1'b0;
    ticks(20, 1);
    chk(fs_out == 1'b0, "R2 run only", fs_out, 0);
    run = 1'b0; free_mode = 1'b1;
    ticks(20, 0);
    chk(fs_out == 1'b0, "R2 mode only", fs_out, 0);

    cur_req = "R3";
    run = 1'b1; width_cfg = 8'd1; period_cfg = 12'd15;
    repeat (3) @(negedge clk);
    chk(fs_out == 1'b0, "R3 no tick yet", fs_out, 0);
    ticks(1, 0);
    chk(fs_out == 1'b1, "R3 first tick", fs_out, 1);

    cur_req = "R4 R5";
    ticks(79, 2);

    cur_req = "R6";
    width_cfg = 8'd3; period_cfg = 12'd9;
    lfsr_ticks(400);

    cur_req = "R7";
    for (int k = 0; k < 4; k++) begin
      ticks(3 + k, 1);
      width_cfg  = 8'(2 + 2 * k);
      period_cfg = 12'(7 + 3 * k);
      ticks(40, 0);
    end

    cur_req = "R8";
    width_cfg = 8'd20; period_cfg = 12'd3;
    ticks(10, 0);
    ticks(30, 1);
    chk(fs_out == 1'b1, "R8 width over period", fs_out, 1);
    width_cfg = 8'd6; period_cfg = 12'd6;
    ticks(30, 0);
    chk(fs_out == 1'b1, "R8 width equals period", fs_out, 1);
    width_cfg = 8'd0; period_cfg = 12'd0;
    ticks(20, 0);
    chk(fs_out == 1'b1, "R8 zero period", fs_out, 1);

    cur_req = "R9";
    width_cfg = 8'd5; period_cfg = 12'd11;
    ticks(14, 0);
    chk(fs_out == 1'b1, "R9 mid pulse", fs_out, 1);
    run = 1'b0;
    @(negedge clk);
    chk(fs_out == 1'b0, "R9 drop run", fs_out, 0);
    run = 1'b1;
    ticks(1, 0);
    chk(fs_out == 1'b1, "R9 fresh start", fs_out, 1);
    ticks(15, 0);
    free_mode = 1'b0;
    @(negedge clk);
    chk(fs_out == 1'b0, "R9 drop mode", fs_out, 0);
    free_mode = 1'b1;
    ticks(20, 0);

    cur_req = "R10";
    stop_gen();
    width_cfg = 8'd0; period_cfg = 12'd4;
    run = 1'b1; free_mode = 1'b1;
    ticks(1, 0);
    chk(fs_out == 1'b1, "R10 one-tick pulse high", fs_out, 1);
    ticks(1, 0);
    chk(fs_out == 1'b0, "R10 one-tick pulse low", fs_out, 0);
    ticks(20, 0);
    stop_gen();
    width_cfg = 8'd255; period_cfg = 12'd4095;
    run = 1'b1; free_mode = 1'b1;
    ticks(256, 0);
    chk(fs_out == 1'b1, "R10 last high tick", fs_out, 1);
    ticks(1, 0);
    chk(fs_out == 1'b0, "R10 after 256", fs_out, 0);
    ticks(3839, 0);
    chk(fs_out == 1'b0, "R10 frame end", fs_out, 0);
    ticks(1, 0);
    chk(fs_out == 1'b1, "R10 new frame at 4096", fs_out, 1);
    ticks(300, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule